// File: doc/BRIEF.md
# Quarter-Rate Complex Downconverter

This block shifts a real, subsampled IF stream down to complex baseband. The converter runs at 4 MSPS, so a 45 MHz carrier folds to an alias at 1 MHz. That alias is exactly one quarter of the sample rate. Each incoming sample is multiplied by the phasor cos − j·sin at that frequency. The real product becomes the in-phase stream and the negated sine product becomes the quadrature stream. Each stream then feeds its own low-pass decimation channel.

At a quarter of the sample rate the oscillator needs only four phases, and every coefficient is +1, −1 or 0. The block therefore holds a two-bit phase counter and two lanes. Each lane passes the widened sample through, negates it, or forces it to zero. It has no phase accumulator, no sine table and no multiplier. The 8-bit two's complement input is sign-extended and shifted left by seven places into the 16-bit two's complement output word. The top bit is left as headroom, so negating the most negative input still fits.

Top module: `qr_ddc_top`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `out_valid`=0, `out_i`=0 and `out_q`=0, and the phase counter returns to phase 0.
- R2: `out_valid` at a rising edge equals `in_valid` sampled at the previous rising edge, outside reset.
- R3: A sample x is widened to the 16-bit value x·128, which is sign extension followed by a left shift of 7.
- R4: For valid samples numbered k = 0, 1, 2, … since reset, the phase is k mod 4. The I coefficient is +1, 0, −1, 0 for phases 0, 1, 2, 3, and the Q coefficient is 0, −1, 0, +1. `out_i` and `out_q` equal the coefficient times the widened sample.
- R5: A cycle with `in_valid`=0 does not advance the phase. The next valid sample uses the same phase it would have used without the gap.
- R6: The input −128 with a coefficient of −1 gives +16384. The result is positive and has no overflow.
- R7: While `in_valid`=0, `out_i` and `out_q` keep their previous values.
- R8: A reset in the middle of a stream restarts the sequence, so the next valid sample uses phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks a new input sample |
| in_sample | input | 8 | Real IF sample, two's complement |
| out_valid | output | 1 | Marks new I and Q results |
| out_i | output | 16 | In-phase result, two's complement |
| out_q | output | 16 | Quadrature result, two's complement |

## Verification
All three results are due exactly one rising edge after the sample that produces them, because each output passes through a single register. The bench drives its inputs on the falling edge. It compares `out_valid`, `out_i` and `out_q` one nanosecond after the next rising edge, against a phase index it keeps in step with its own count of valid samples. Idle cycles are checked at the same point: `out_valid` must be low and both data outputs must be unchanged. A reset applied in the middle of the stream is checked the same way, one edge later.

// File: rtl/qr_ddc_pkg.sv
package qr_ddc_pkg;

  // Quarter-rate oscillator phase: 0..3
  typedef logic [1:0] qr_phase_t;

  // Mixing coefficient applied to one lane
  typedef enum logic [1:0] {
    CF_ZERO = 2'd0,
    CF_POS  = 2'd1,
    CF_NEG  = 2'd2
  } qr_coef_e;

  // Cosine at fs/4: +1, 0, -1, 0
  function automatic qr_coef_e qr_cos_coef(input qr_phase_t ph);
    case (ph)
      2'd0:    return CF_POS;
      2'd2:    return CF_NEG;
      default: return CF_ZERO;
    endcase
  endfunction

  // Negated sine at fs/4: 0, -1, 0, +1
  function automatic qr_coef_e qr_nsin_coef(input qr_phase_t ph);
    case (ph)
      2'd1:    return CF_NEG;
      2'd3:    return CF_POS;
      default: return CF_ZERO;
    endcase
  endfunction

endpackage

// File: rtl/qr_phase_seq.sv
module qr_phase_seq
  import qr_ddc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      advance,
  output qr_phase_t phase
);

  qr_phase_t phase_q;

  always_ff @(posedge clk) begin
    if (rst)          phase_q <= '0;
    else if (advance) phase_q <= phase_q + 2'd1;
  end

  assign phase = phase_q;

  // R4: every accepted sample moves the oscillator one quarter turn
  a_r4_phase_step: assert property (@(posedge clk) disable iff (rst)
    advance |=> (phase_q == 2'($past(phase_q) + 2'd1)));

  // R5: idle cycles leave the oscillator where it was
  a_r5_phase_hold: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(phase_q));

  // R1: reset returns to phase 0
  a_r1_phase_reset: assert property (@(posedge clk)
    rst |=> (phase_q == 2'd0));

endmodule

// File: rtl/qr_mix_lane.sv
module qr_mix_lane
  import qr_ddc_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int OUT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  qr_coef_e                coef,
  input  logic signed [IN_W-1:0]  sample,
  output logic signed [OUT_W-1:0] value
);

  // One bit of headroom so negating the most negative input fits
  localparam int SHIFT = OUT_W - IN_W - 1;
  localparam int EXT   = OUT_W - IN_W;
  localparam logic signed [IN_W-1:0] IN_MIN = {1'b1, {(IN_W-1){1'b0}}};

  function automatic logic signed [OUT_W-1:0] widen(input logic signed [IN_W-1:0] s);
    logic signed [OUT_W-1:0] w;
    w = {{EXT{s[IN_W-1]}}, s};
    return w <<< SHIFT;
  endfunction

  function automatic logic signed [OUT_W-1:0] mix(input qr_coef_e c,
                                                 input logic signed [OUT_W-1:0] v);
    case (c)
      CF_POS:  return v;
      CF_NEG:  return -v;
      default: return '0;
    endcase
  endfunction

  logic signed [OUT_W-1:0] widened;
  logic signed [OUT_W-1:0] product;
  logic signed [OUT_W-1:0] value_q;

  assign widened = widen(sample);
  assign product = mix(coef, widened);

  always_ff @(posedge clk) begin
    if (rst)       value_q <= '0;
    else if (load) value_q <= product;
  end

  assign value = value_q;

  // R4: a zero coefficient yields zero
  a_r4_zero_coef: assert property (@(posedge clk) disable iff (rst)
    (load && coef == CF_ZERO) |=> (value_q == '0));

  // R6: negating the most negative sample gives a positive result
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (load && coef == CF_NEG && sample == IN_MIN) |=> (value_q > 0));

  // R7: no load, no change
  a_r7_lane_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(value_q));

endmodule

// File: rtl/qr_ddc_top.sv
module qr_ddc_top
  import qr_ddc_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int OUT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_sample,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_i,
  output logic signed [OUT_W-1:0] out_q
);

  localparam int N_LANES = 2;  // lane 0 = I, lane 1 = Q

  qr_phase_t               phase;
  logic                    sample_take;
  qr_coef_e                lane_coef [N_LANES];
  logic signed [OUT_W-1:0] lane_out  [N_LANES];
  logic                    valid_q;

  assign sample_take = in_valid;

  qr_phase_seq u_phase (
    .clk     (clk),
    .rst     (rst),
    .advance (sample_take),
    .phase   (phase)
  );

  for (genvar k = 0; k < N_LANES; k++) begin : g_lane
    if (k == 0) begin : g_cos
      assign lane_coef[k] = qr_cos_coef(phase);
    end else begin : g_sin
      assign lane_coef[k] = qr_nsin_coef(phase);
    end

    qr_mix_lane #(.IN_W(IN_W), .OUT_W(OUT_W)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .load   (sample_take),
      .coef   (lane_coef[k]),
      .sample (in_sample),
      .value  (lane_out[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= in_valid;
  end

  assign out_valid = valid_q;
  assign out_i     = lane_out[0];
  assign out_q     = lane_out[1];

  // R2: valid follows the input one edge later
  a_r2_valid_rise: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r2_valid_fall: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R4: at fs/4 only one of I and Q can be nonzero for any sample
  a_r4_one_lane: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_i == '0 || out_q == '0));

  // R7: outputs hold across idle cycles
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_i) && $stable(out_q)));

  // R1: reset clears the outputs
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && out_i == '0 && out_q == '0));

endmodule

// File: tb/sim_qr_ddc_top.sv
`timescale 1ns/1ps
module sim_qr_ddc_top;

  logic              clk = 1'b0;
  logic              rst;
  logic              in_valid;
  logic signed [7:0] in_sample;
  logic              out_valid;
  logic signed [15:0] out_i;
  logic signed [15:0] out_q;

  int n_checks = 0;
  int n_errors = 0;
  int exp_ph   = 0;
  int prev_i   = 0;
  int prev_q   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  qr_ddc_top u0 (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q)
  );

  task automatic check(input string req, input int actual, input int expected);
    n_checks++;
    if (actual != expected) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  // Drive on the falling edge, check just after the next rising edge
  task automatic step(input bit r, input bit v, input int s);
    int ci, sq, wide, ei, eq;
    @(negedge clk);
    rst       = r;
    in_valid  = v;
    in_sample = 8'(s);
    @(posedge clk);
    #1;
    if (r) begin
      check("R1 valid", int'(out_valid), 0);
      check("R1 i", int'(out_i), 0);
      check("R1 q", int'(out_q), 0);
      exp_ph = 0; prev_i = 0; prev_q = 0;
    end else if (!v) begin
      check("R2 idle valid", int'(out_valid), 0);
      check("R7 hold i", int'(out_i), prev_i);
      check("R7 hold q", int'(out_q), prev_q);
    end else begin
      ci   = ((exp_ph + 1) % 2) * (1 - exp_ph);   // +1,0,-1,0
      sq   = (exp_ph % 2) * (exp_ph - 2);          // 0,-1,0,+1
      wide = s * 128;
      ei   = ci * wide;
      eq   = sq * wide;
      check("R2 valid", int'(out_valid), 1);
      if (s == -128 && (ci == -1 || sq == -1)) begin
        check("R6 i", int'(out_i), ei);
        check("R6 q", int'(out_q), eq);
      end else begin
        check("R4 i", int'(out_i), ei);
        check("R4 q", int'(out_q), eq);
      end
      prev_i = ei; prev_q = eq;
      exp_ph = (exp_ph + 1) % 4;
    end
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_sample = '0;
    repeat (3) step(1, 0, 0);               // R1
    // R3/R4: every sample value at every phase, with idle gaps (R5, R7)
    for (int i = 0; i < 1024; i++) begin
      if (i % 9 == 4) step(0, 0, 85);
      step(0, 1, (i >> 2) - 128);
    end
    // R3: plain scaling of a few values at phase 0 after reset
    step(1, 0, 0);
    step(0, 1, 1);
    check("R3 scale one", int'(out_i), 128);
    step(0, 1, 127);
    step(0, 1, -1);
    check("R3 scale neg", int'(out_i), 128);
    // R8: reset in the middle of a stream
    step(0, 1, 9);
    step(0, 1, 33);
    step(1, 1, 44);
    step(0, 1, 5);
    check("R8 restart i", int'(out_i), 640);
    check("R8 restart q", int'(out_q), 0);
    step(0, 0, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule